// File: doc/BRIEF.md
# Indirect Bus Access Bridge

This block lets a host reach a 32-bit internal peripheral address space through four 64-bit registers. The host first loads a 32-bit word into the data register, then writes a command word carrying a read flag, a byte count and a target address. That command write starts one transaction on a simple downstream valid/ready bus. The outcome is posted in a status register that clears itself when it is read.

Bits [4:3] of the host byte address pick one of the four registers. All other address bits are ignored. Every host access is a full 64-bit word. Downstream data is big-endian: the first byte of a transfer travels in bits [31:24]. Only one downstream transaction may be in flight at a time.

Top module: `ind_bus_bridge`

## Requirements
- R1: Bits [4:3] of the host byte address select the register: 0 command, 1 reset, 2 status, 3 data. Other address bits have no effect. Reads of the command and reset registers return zero.
- R2: A command write made while no transaction is pending, with byte count hwdata[59:56] at most 8, raises dn_valid in the next cycle. dn_addr equals hwdata[31:0], dn_len equals the count, and dn_we is the inverse of hwdata[48] (1 means read).
- R3: A command write with a byte count above 8 is rejected. No downstream transaction starts and the status register keeps its value.
- R4: A successful read sets the status word to the done flag (bit 11) plus the read data in bits [57:26]. Byte lane i, counted from bits [31:24] downward, is kept only when i is less than the byte count; the other lanes read as zero.
- R5: A read that completes with dn_err set posts the done flag with all ones in bits [57:26].
- R6: A write transaction drives dn_wdata with the data register. On completion the status becomes the done flag alone, whether or not dn_err is set.
- R7: A host read of the status register returns its value and clears it to zero, so a second read returns zero.
- R8: A write to the data register captures hwdata[63:32]. A read of the data register returns the stored word in bits [63:32] with zeros below.
- R9: Writes to the reset and status registers change neither the status nor the data register.
- R10: While a transaction is pending, dn_valid, dn_addr, dn_len and dn_we hold until dn_ready. A further command write in that time is ignored, and the status register does not change before the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_sel | input | 1 | Host access strobe, one cycle per access |
| h_wr | input | 1 | 1 write, 0 read |
| h_addr | input | HADDR_W | Host byte address |
| h_wdata | input | 64 | Host write word |
| h_rdata | output | 64 | Host read word, valid while h_sel is high and h_wr is low |
| dn_valid | output | 1 | Downstream request pending |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | 32 | Downstream target address |
| dn_len | output | 4 | Downstream byte count |
| dn_wdata | output | 32 | Downstream write data, first byte in [31:24] |
| dn_ready | input | 1 | Downstream acknowledge |
| dn_rdata | input | 32 | Downstream read data, first byte in [31:24] |
| dn_err | input | 1 | Downstream error, sampled with dn_ready |

## Verification
The assertions assume that the host raises h_sel for single-cycle accesses and that dn_rdata and dn_err are meaningful only in the cycle dn_ready is high. They also assume dn_ready is never raised while dn_valid is low. The bench's downstream model raises dn_ready only after it has seen dn_valid, holds it for exactly one cycle after a random delay of zero to three cycles, and drives rdata and err only in that cycle. Host accesses are issued one at a time on falling edges and dropped after one rising edge. Directed cases cover counts of 0, 4, 8 and 9, command writes issued while a transaction is pending, and address aliasing through the upper address bits.

// File: rtl/ind_bus_bridge.sv
module ind_bus_bridge #(
  parameter int HADDR_W   = 8,
  parameter int MAX_BYTES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               h_sel,
  input  logic               h_wr,
  input  logic [HADDR_W-1:0] h_addr,
  input  logic [63:0]        h_wdata,
  output logic [63:0]        h_rdata,
  output logic               dn_valid,
  output logic               dn_we,
  output logic [31:0]        dn_addr,
  output logic [3:0]         dn_len,
  output logic [31:0]        dn_wdata,
  input  logic               dn_ready,
  input  logic [31:0]        dn_rdata,
  input  logic               dn_err
);
  localparam logic [1:0] SEL_CMD = 2'd0, SEL_RST = 2'd1, SEL_STAT = 2'd2, SEL_DATA = 2'd3;
  localparam int RD_FLAG = 48;
  localparam int LEN_LO  = 56;
  localparam int DONE_B  = 11;
  localparam int DAT_LO  = 26;
  localparam int LANES   = 4;

  logic [1:0]  rsel;
  logic [3:0]  cmd_len;
  logic        cmd_go, stat_rd, finish;
  logic        pend_q, we_q, st_done_q;
  logic [31:0] addr_q, data_q, st_data_q, lane_mask;
  logic [3:0]  len_q;
  logic [63:0] stat_word;

  assign rsel    = h_addr[4:3];
  assign cmd_len = h_wdata[LEN_LO+3:LEN_LO];
  assign cmd_go  = h_sel && h_wr && rsel == SEL_CMD && !pend_q &&
                   ({28'd0, cmd_len} <= MAX_BYTES);
  assign stat_rd = h_sel && !h_wr && rsel == SEL_STAT;
  assign finish  = pend_q && dn_ready;

  always_comb begin
    for (int i = 0; i < LANES; i++)
      lane_mask[31-8*i -: 8] = ({28'd0, len_q} > i) ? 8'hFF : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      len_q  <= '0;
    end else if (cmd_go) begin
      pend_q <= 1'b1;
      we_q   <= !h_wdata[RD_FLAG];
      addr_q <= h_wdata[31:0];
      len_q  <= cmd_len;
    end else if (finish) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      data_q <= '0;
    else if (h_sel && h_wr && rsel == SEL_DATA)
      data_q <= h_wdata[63:32];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_done_q <= 1'b0;
      st_data_q <= '0;
    end else if (finish) begin
      st_done_q <= 1'b1;
      if (we_q)        st_data_q <= '0;
      else if (dn_err) st_data_q <= '1;
      else             st_data_q <= dn_rdata & lane_mask;
    end else if (stat_rd) begin
      st_done_q <= 1'b0;
      st_data_q <= '0;
    end
  end

  assign stat_word = {6'd0, st_data_q, 14'd0, st_done_q, 11'd0};

  always_comb begin
    h_rdata = '0;
    if (h_sel && !h_wr) begin
      case (rsel)
        SEL_STAT: h_rdata = stat_word;
        SEL_DATA: h_rdata = {data_q, 32'd0};
        default:  h_rdata = '0;
      endcase
    end
  end

  assign dn_valid = pend_q;
  assign dn_we    = we_q;
  assign dn_addr  = addr_q;
  assign dn_len   = len_q;
  assign dn_wdata = data_q;

  a_r2_launch: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && h_wr && h_addr[4:3] == 2'd0 && !dn_valid && h_wdata[59:56] <= 4'd8)
    |=> (dn_valid && dn_addr == $past(h_wdata[31:0]) && dn_we == !$past(h_wdata[48])));

  a_r3_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && h_wr && h_addr[4:3] == 2'd0 && !dn_valid && h_wdata[59:56] > 4'd8)
    |=> (!dn_valid && $stable(stat_word)));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && !dn_ready)
    |=> (dn_valid && $stable(dn_addr) && $stable(dn_len) && $stable(dn_we)));

  a_r5_read_fail: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && !dn_we && dn_err)
    |=> (st_done_q && st_data_q == 32'hFFFF_FFFF));

  a_r6_write_done: assert property (@(posedge clk) disable iff (!rst_n)
    (dn_valid && dn_ready && dn_we)
    |=> (st_done_q && st_data_q == 32'd0));

  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (h_sel && !h_wr && h_addr[4:3] == 2'd2 && !(dn_valid && dn_ready))
    |=> (stat_word == 64'd0));
endmodule

// File: tb/ind_bus_bridge_tb.sv
module ind_bus_bridge_tb_top;
  logic        clk = 0, rst_n = 0;
  logic        h_sel = 0, h_wr = 0;
  logic [7:0]  h_addr = 0;
  logic [63:0] h_wdata = 0, h_rdata;
  logic        dn_valid, dn_we, dn_ready = 0, dn_err = 0;
  logic [31:0] dn_addr, dn_wdata, dn_rdata = 0;
  logic [3:0]  dn_len;
  int checks = 0, errors = 0;
  logic [31:0] data_m = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ind_bus_bridge dut_i (.clk, .rst_n, .h_sel, .h_wr, .h_addr, .h_wdata, .h_rdata,
    .dn_valid, .dn_we, .dn_addr, .dn_len, .dn_wdata, .dn_ready, .dn_rdata, .dn_err);

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk); h_sel = 1; h_wr = 1; h_addr = a; h_wdata = d;
    @(negedge clk); h_sel = 0; h_wr = 0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk); h_sel = 1; h_wr = 0; h_addr = a;
    #1 d = h_rdata;
    @(negedge clk); h_sel = 0;
  endtask

  function automatic logic [63:0] cmd(input bit rd, input logic [3:0] len, input logic [31:0] a);
    return {4'd0, len, 7'd0, rd, 16'd0, a};
  endfunction

  function automatic logic [63:0] exp_stat(input bit rd, input logic [3:0] len,
                                           input logic [31:0] rdat, input bit err);
    logic [31:0] m;
    for (int i = 0; i < 4; i++) m[31-8*i -: 8] = (len > i) ? 8'hFF : 8'h00;
    if (!rd) return 64'h800;
    if (err) return (64'hFFFF_FFFF << 26) | 64'h800;
    return ({32'd0, rdat & m} << 26) | 64'h800;
  endfunction

  task automatic respond(input int dly, input logic [31:0] rdat, input bit err);
    repeat (dly) @(negedge clk);
    dn_ready = 1; dn_rdata = rdat; dn_err = err;
    @(negedge clk); dn_ready = 0; dn_err = 0; dn_rdata = 0;
  endtask

  task automatic run_op(input bit rd, input logic [3:0] len, input logic [31:0] a,
                        input int dly, input logic [31:0] rdat, input bit err, input string tag);
    logic [63:0] s;
    hwr(8'h00, cmd(rd, len, a));
    chk(dn_valid && dn_addr == a && dn_len == len && dn_we == !rd, {tag, " R2 launch"},
        {dn_valid, dn_we, dn_len, dn_addr}, {1'b1, !rd, len, a});
    if (!rd) chk(dn_wdata == data_m, {tag, " R6 wdata"}, dn_wdata, data_m);
    respond(dly, rdat, err);
    hrd(8'h10, s);
    chk(s == exp_stat(rd, len, rdat, err), {tag, rd ? " R4/R5 status" : " R6 status"},
        s, exp_stat(rd, len, rdat, err));
    hrd(8'h10, s);
    chk(s == 0, {tag, " R7 cleared"}, s, 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] r;
    void'($urandom(32'h1BADB002));
    repeat (3) @(negedge clk);
    rst_n = 1;
    hrd(8'h10, r); chk(r == 0 && !dn_valid, "reset status", r, 0);
    hrd(8'h00, r); chk(r == 0, "R1 command reads zero", r, 0);
    hrd(8'h08, r); chk(r == 0, "R1 reset reads zero", r, 0);

    data_m = 32'hA1B2C3D4;
    hwr(8'h58, {data_m, 32'hFFFF_FFFF});
    hrd(8'h18, r); chk(r == {data_m, 32'd0}, "R8 R1 data alias", r, {data_m, 32'd0});

    run_op(1, 4, 32'h1000_0040, 0, 32'h11223344, 0, "rd4");
    run_op(1, 1, 32'h0000_0003, 2, 32'hAABBCCDD, 0, "R4 rd1 lane");
    run_op(1, 0, 32'h0000_0007, 1, 32'hAABBCCDD, 0, "R4 rd0");
    run_op(1, 8, 32'hFFFF_FFFC, 3, 32'h01020304, 1, "R5 rderr");
    run_op(0, 4, 32'h2000_0000, 1, 32'h0, 1, "R6 wrerr");

    hwr(8'h00, cmd(0, 2, 32'h300));
    respond(0, 0, 0);
    hwr(8'h00, cmd(1, 9, 32'h400));
    chk(!dn_valid, "R3 no launch", dn_valid, 0);
    hwr(8'h10, 64'hFFFF_FFFF_FFFF_FFFF);
    hwr(8'h08, 64'hFFFF_FFFF_FFFF_FFFF);
    hrd(8'h10, r); chk(r == 64'h800, "R3 R9 status kept", r, 64'h800);
    hrd(8'h18, r); chk(r == {data_m, 32'd0}, "R9 data kept", r, {data_m, 32'd0});

    hwr(8'h00, cmd(1, 4, 32'h500));
    repeat (2) @(negedge clk);
    hwr(8'h00, cmd(0, 1, 32'h600));
    chk(dn_valid && dn_addr == 32'h500 && !dn_we, "R10 ignored", dn_addr, 32'h500);
    hrd(8'h10, r); chk(r == 0, "R10 status before ack", r, 0);
    respond(0, 32'hCAFEF00D, 0);
    hrd(8'h10, r); chk(r == exp_stat(1, 4, 32'hCAFEF00D, 0), "R10 first op result",
                       r, exp_stat(1, 4, 32'hCAFEF00D, 0));

    for (int n = 0; n < 40; n++) begin
      bit rd = $urandom_range(1, 0);
      logic [3:0] len = 4'($urandom_range(8, 0));
      logic [31:0] a = $urandom;
      logic [31:0] rdat = $urandom;
      bit err = ($urandom_range(3, 0) == 0);
      data_m = $urandom;
      hwr(8'($urandom_range(7, 0) << 5) | 8'h18, {data_m, 32'($urandom)});
      run_op(rd, len, a, $urandom_range(3, 0), rdat, err, "random");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule